// File: doc/BRIEF.md
# Row-Pipelined Array Operation Controller

This block sequences operations through a reconfigurable array built as a stack of rows, where each row is one stage of a custom pipeline. The processor issues an operation with an operation number, two or four 32-bit operands and two destination register indices. The controller then walks a valid token down the rows. Each row computes only in the cycle its enable is raised. After a number of rows that depends on the operation number, the controller presents two 32-bit results with their destination indices for one cycle.

Issue never waits for a result. Several operations can occupy different rows at once, so the array runs alongside the processor pipeline. The only back-pressure is an issue stall. It is raised when a new operation, being shorter than one already in flight, would write back in the same cycle as that operation or before it. This keeps results in issue order and leaves the result port with at most one writer.

In this project the per-row cell function is a fixed placeholder. For a word set (a, b, c, d), one row produces (a+b, b^c, c+d, d rotated left by one bit). Result 0 is the final a and result 1 is the final b.

Top module: `rowpipe_ctrl`

## Requirements
- R1: While rst_ni is low, and in every cycle after its release until the next accepted issue, row_en_o is all zero, res_valid_o is 0 and issue_ready_o is 1.
- R2: An operation accepted at a rising edge (issue_valid_i and issue_ready_o both high) raises row_en_o[r] in the (r+1)-th cycle after that edge, for r = 0 to L-1. It raises no row from L upward.
- R3: The row count L of an operation is (issue_op_i mod NUM_ROWS) + 1. res_valid_o rises in the L-th cycle after the accepting edge, which is the cycle of its last row enable.
- R4: res_valid_o is high for exactly one cycle per accepted operation. In that cycle res_dst0_o and res_dst1_o carry the destination indices given at issue.
- R5: For a long-form issue (issue_long_i = 1), res0_o and res1_o equal the words a and b after L applications of the row function to (src0, src1, src2, src3).
- R6: For a short-form issue (issue_long_i = 0), src2 and src3 are ignored and treated as zero. The results depend only on src0 and src1.
- R7: issue_ready_o is low exactly when the new row count L is less than T. T is the number of cycles, counting the current one, until the youngest in-flight result has been delivered. As a result, results leave in issue order and at most one per cycle.
- R8: Operations issued on consecutive cycles with non-decreasing row counts are all accepted. Their tokens occupy distinct rows at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_ready_o | output | 1 | Issue accepted when high together with valid |
| issue_op_i | input | OP_W | Operation number, selects the row count |
| issue_long_i | input | 1 | 1: four operands, 0: two operands |
| issue_src0_i | input | DATA_W | Operand a |
| issue_src1_i | input | DATA_W | Operand b |
| issue_src2_i | input | DATA_W | Operand c (long form only) |
| issue_src3_i | input | DATA_W | Operand d (long form only) |
| issue_dst0_i | input | REG_W | Destination index for result 0 |
| issue_dst1_i | input | REG_W | Destination index for result 1 |
| row_en_o | output | NUM_ROWS | Per-row execution enable |
| res_valid_o | output | 1 | Result strobe, one cycle per operation |
| res0_o | output | DATA_W | Result 0 |
| res1_o | output | DATA_W | Result 1 |
| res_dst0_o | output | REG_W | Destination index of result 0 |
| res_dst1_o | output | REG_W | Destination index of result 1 |

## Verification
The colliding functions are the writeback of an older, longer operation and the writeback of a newer, shorter one. Both would land on the single result port in the same cycle. The bench provokes this by issuing row counts in falling order back to back, by repeating equal counts, and by a random burst. A queue-based model predicts the stall cycle, every row enable and the single result of each cycle. On every cycle it checks that the stall appears exactly when predicted and that each result arrives alone and in issue order.

// File: rtl/rowpipe_pkg.sv
package rowpipe_pkg;
  localparam int DATA_W = 32;
  localparam int REG_W  = 5;

  typedef struct packed {
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
    logic [DATA_W-1:0] c;
    logic [DATA_W-1:0] d;
  } quad_t;

  // placeholder cell function applied by one enabled row
  function automatic quad_t row_step(input quad_t x);
    quad_t y;
    y.a = x.a + x.b;
    y.b = x.b ^ x.c;
    y.c = x.c + x.d;
    y.d = {x.d[DATA_W-2:0], x.d[DATA_W-1]};
    return y;
  endfunction
endpackage

// File: rtl/rowpipe_issue_gate.sv
module rowpipe_issue_gate #(
  parameter int NUM_ROWS = 8,
  parameter int OP_W     = 4,
  localparam int CNT_W   = $clog2(NUM_ROWS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic [CNT_W-1:0] rows_o
);
  logic [CNT_W-1:0] tail_q;

  always_comb begin
    rows_o   = CNT_W'((int'(op_i) % NUM_ROWS) + 1);
    ready_o  = (rows_o >= tail_q);
    accept_o = valid_i && ready_o;
  end

  // tail_q: cycles left until the youngest result has been delivered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tail_q <= '0;
    else if (accept_o)          tail_q <= rows_o;
    else if (tail_q != '0)      tail_q <= tail_q - 1'b1;
  end
endmodule

// File: rtl/rowpipe_row.sv
module rowpipe_row
  import rowpipe_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [CNT_W-1:0] in_left_i,
  input  quad_t            in_data_i,
  input  logic [REG_W-1:0] in_dst0_i,
  input  logic [REG_W-1:0] in_dst1_i,
  output logic             en_o,
  output logic             done_o,
  output logic             fwd_o,
  output logic [CNT_W-1:0] left_o,
  output quad_t            data_o,
  output logic [REG_W-1:0] dst0_o,
  output logic [REG_W-1:0] dst1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      left_o <= '0;
      data_o <= '0;
      dst0_o <= '0;
      dst1_o <= '0;
    end else begin
      en_o <= in_valid_i;
      if (in_valid_i) begin
        data_o <= row_step(in_data_i);
        left_o <= in_left_i;
        dst0_o <= in_dst0_i;
        dst1_o <= in_dst1_i;
      end
    end
  end

  assign done_o = en_o && (left_o == CNT_W'(1));
  assign fwd_o  = en_o && (left_o > CNT_W'(1));
endmodule

// File: rtl/rowpipe_wb_sel.sv
module rowpipe_wb_sel
  import rowpipe_pkg::*;
#(
  parameter int NUM_ROWS = 8
) (
  input  logic [NUM_ROWS-1:0] done_i,
  input  quad_t               data_i [NUM_ROWS],
  input  logic [REG_W-1:0]    dst0_i [NUM_ROWS],
  input  logic [REG_W-1:0]    dst1_i [NUM_ROWS],
  output logic                valid_o,
  output logic [DATA_W-1:0]   res0_o,
  output logic [DATA_W-1:0]   res1_o,
  output logic [REG_W-1:0]    dst0_o,
  output logic [REG_W-1:0]    dst1_o
);
  // issue gate guarantees at most one finishing row
  always_comb begin
    valid_o = |done_i;
    res0_o  = '0;
    res1_o  = '0;
    dst0_o  = '0;
    dst1_o  = '0;
    for (int i = 0; i < NUM_ROWS; i++) begin
      if (done_i[i]) begin
        res0_o |= data_i[i].a;
        res1_o |= data_i[i].b;
        dst0_o |= dst0_i[i];
        dst1_o |= dst1_i[i];
      end
    end
  end
endmodule

// File: rtl/rowpipe_ctrl.sv
module rowpipe_ctrl
  import rowpipe_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int OP_W     = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                issue_valid_i,
  output logic                issue_ready_o,
  input  logic [OP_W-1:0]     issue_op_i,
  input  logic                issue_long_i,
  input  logic [DATA_W-1:0]   issue_src0_i,
  input  logic [DATA_W-1:0]   issue_src1_i,
  input  logic [DATA_W-1:0]   issue_src2_i,
  input  logic [DATA_W-1:0]   issue_src3_i,
  input  logic [REG_W-1:0]    issue_dst0_i,
  input  logic [REG_W-1:0]    issue_dst1_i,
  output logic [NUM_ROWS-1:0] row_en_o,
  output logic                res_valid_o,
  output logic [DATA_W-1:0]   res0_o,
  output logic [DATA_W-1:0]   res1_o,
  output logic [REG_W-1:0]    res_dst0_o,
  output logic [REG_W-1:0]    res_dst1_o
);
  localparam int CNT_W = $clog2(NUM_ROWS + 1);

  logic             accept;
  logic [CNT_W-1:0] issue_rows;
  quad_t            issue_quad;

  logic [NUM_ROWS-1:0] row_done;
  logic [NUM_ROWS-1:0] row_fwd;
  logic [CNT_W-1:0]    row_left [NUM_ROWS];
  quad_t               row_data [NUM_ROWS];
  logic [REG_W-1:0]    row_dst0 [NUM_ROWS];
  logic [REG_W-1:0]    row_dst1 [NUM_ROWS];
  logic [CNT_W-1:0]    last_left;

  rowpipe_issue_gate #(.NUM_ROWS(NUM_ROWS), .OP_W(OP_W)) i_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (issue_valid_i),
    .op_i    (issue_op_i),
    .ready_o (issue_ready_o),
    .accept_o(accept),
    .rows_o  (issue_rows)
  );

  // short form: upper operand pair forced to zero
  always_comb begin
    issue_quad.a = issue_src0_i;
    issue_quad.b = issue_src1_i;
    issue_quad.c = issue_long_i ? issue_src2_i : '0;
    issue_quad.d = issue_long_i ? issue_src3_i : '0;
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    logic             in_valid;
    logic [CNT_W-1:0] in_left;
    quad_t            in_data;
    logic [REG_W-1:0] in_dst0;
    logic [REG_W-1:0] in_dst1;

    if (r == 0) begin : g_head
      assign in_valid = accept;
      assign in_left  = issue_rows;
      assign in_data  = issue_quad;
      assign in_dst0  = issue_dst0_i;
      assign in_dst1  = issue_dst1_i;
    end else begin : g_body
      assign in_valid = row_fwd[r-1];
      assign in_left  = row_left[r-1] - 1'b1;
      assign in_data  = row_data[r-1];
      assign in_dst0  = row_dst0[r-1];
      assign in_dst1  = row_dst1[r-1];
    end

    rowpipe_row #(.CNT_W(CNT_W)) i_row (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .in_valid_i(in_valid),
      .in_left_i (in_left),
      .in_data_i (in_data),
      .in_dst0_i (in_dst0),
      .in_dst1_i (in_dst1),
      .en_o      (row_en_o[r]),
      .done_o    (row_done[r]),
      .fwd_o     (row_fwd[r]),
      .left_o    (row_left[r]),
      .data_o    (row_data[r]),
      .dst0_o    (row_dst0[r]),
      .dst1_o    (row_dst1[r])
    );
  end

  assign last_left = row_left[NUM_ROWS-1];

  rowpipe_wb_sel #(.NUM_ROWS(NUM_ROWS)) i_wb (
    .done_i (row_done),
    .data_i (row_data),
    .dst0_i (row_dst0),
    .dst1_i (row_dst1),
    .valid_o(res_valid_o),
    .res0_o (res0_o),
    .res1_o (res1_o),
    .dst0_o (res_dst0_o),
    .dst1_o (res_dst1_o)
  );
endmodule

// File: rtl/rowpipe_ctrl_chk.sv
module rowpipe_ctrl_chk #(
  parameter int NUM_ROWS = 8,
  localparam int CNT_W   = $clog2(NUM_ROWS + 1)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                issue_valid_i,
  input logic                issue_ready_o,
  input logic [NUM_ROWS-1:0] row_en_o,
  input logic                res_valid_o,
  input logic [NUM_ROWS-1:0] row_done,
  input logic [NUM_ROWS-1:0] row_fwd,
  input logic [CNT_W-1:0]    last_left
);
  assert_idle_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (row_en_o == '0 && !res_valid_o));

  for (genvar r = 1; r < NUM_ROWS; r++) begin : g_chain
    assert_row_chain_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      row_en_o[r] |-> $past(row_en_o[r-1]));
  end

  assert_no_exit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !row_fwd[NUM_ROWS-1]);

  assert_last_row_final_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_en_o[NUM_ROWS-1] |-> last_left == CNT_W'(1));

  assert_result_has_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> ($past(row_en_o) != '0 || $past(issue_valid_i && issue_ready_o)));

  assert_single_writer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_done));

  assert_stall_needs_flight_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_ready_o |-> row_en_o != '0);
endmodule

bind rowpipe_ctrl rowpipe_ctrl_chk #(.NUM_ROWS(NUM_ROWS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_valid_i(issue_valid_i),
  .issue_ready_o(issue_ready_o),
  .row_en_o     (row_en_o),
  .res_valid_o  (res_valid_o),
  .row_done     (row_done),
  .row_fwd      (row_fwd),
  .last_left    (last_left)
);

// File: tb/test_rowpipe_ctrl.sv
module test_rowpipe_ctrl;
  localparam int NR  = 8;
  localparam int OPW = 4;
  localparam int DW  = 32;
  localparam int RW  = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_ni;
  logic          issue_valid, issue_ready, issue_long;
  logic [OPW-1:0] issue_op;
  logic [DW-1:0] src0, src1, src2, src3;
  logic [RW-1:0] dst0, dst1;
  logic [NR-1:0] row_en;
  logic          res_valid;
  logic [DW-1:0] res0, res1;
  logic [RW-1:0] rdst0, rdst1;

  rowpipe_ctrl #(.NUM_ROWS(NR), .OP_W(OPW)) i_rowpipe_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid), .issue_ready_o(issue_ready),
    .issue_op_i(issue_op), .issue_long_i(issue_long),
    .issue_src0_i(src0), .issue_src1_i(src1), .issue_src2_i(src2), .issue_src3_i(src3),
    .issue_dst0_i(dst0), .issue_dst1_i(dst1),
    .row_en_o(row_en), .res_valid_o(res_valid),
    .res0_o(res0), .res1_o(res1), .res_dst0_o(rdst0), .res_dst1_o(rdst1)
  );

  typedef struct {
    int            e;
    int            len;
    logic [DW-1:0] r0, r1;
    logic [RW-1:0] d0, d1;
    bit            shrt;
  } tok_t;

  tok_t q[$];
  int now = 0;
  int errors = 0;
  int checks = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, now, act, exp);
    end
  endtask

  // reference: L row passes over the operand set
  function automatic void calc(input int len, input bit lng,
                               input logic [DW-1:0] a0, b0, c0, d0v,
                               output logic [DW-1:0] ra, rb);
    logic [DW-1:0] a, b, c, d, na, nb, nc, nd;
    a = a0; b = b0; c = lng ? c0 : '0; d = lng ? d0v : '0;
    for (int k = 0; k < len; k++) begin
      na = a + b; nb = b ^ c; nc = c + d; nd = {d[DW-2:0], d[DW-1]};
      a = na; b = nb; c = nc; d = nd;
    end
    ra = a; rb = b;
  endfunction

  // one cycle: inputs already driven just after a falling edge
  task automatic cycle(output bit acc);
    int tmax, len, inflight, hit;
    logic [NR-1:0] exp_en;
    bit exp_rdy;
    tok_t t;
    #1;
    tmax = 0; exp_en = '0; inflight = 0; hit = -1;
    foreach (q[i]) begin
      int tl, r;
      tl = q[i].e + q[i].len + 1 - now;
      if (tl > tmax) tmax = tl;
      r = now - q[i].e - 1;
      if (r >= 0 && r < q[i].len) begin
        exp_en[r] = 1'b1;
        inflight++;
      end
      if (q[i].e + q[i].len == now) hit = i;
    end
    len = (int'(issue_op) % NR) + 1;
    exp_rdy = (len >= tmax);
    chk(issue_ready == exp_rdy, "R7", "issue_ready", 64'(issue_ready), 64'(exp_rdy));
    chk(row_en == exp_en, "R2", "row_en", 64'(row_en), 64'(exp_en));
    if (inflight >= 2)
      chk($countones(row_en) == inflight, "R8", "rows busy", 64'($countones(row_en)), 64'(inflight));
    chk(res_valid == (hit >= 0), "R3", "res_valid", 64'(res_valid), 64'(hit >= 0));
    if (hit >= 0) begin
      chk(rdst0 == q[hit].d0 && rdst1 == q[hit].d1, "R4", "dests",
          {32'(rdst0), 32'(rdst1)}, {32'(q[hit].d0), 32'(q[hit].d1)});
      chk(res0 == q[hit].r0 && res1 == q[hit].r1, q[hit].shrt ? "R6" : "R5", "results",
          {res0, res1}, {q[hit].r0, q[hit].r1});
    end
    acc = issue_valid && exp_rdy;
    if (acc) begin
      t.e = now; t.len = len; t.d0 = dst0; t.d1 = dst1; t.shrt = !issue_long;
      calc(len, issue_long, src0, src1, src2, src3, t.r0, t.r1);
      q.push_back(t);
    end
    for (int i = q.size() - 1; i >= 0; i--)
      if (q[i].e + q[i].len <= now) q.delete(i);
    @(posedge clk);
    now++;
    @(negedge clk);
  endtask

  task automatic set_ops(input bit v, input int op, input bit lng);
    issue_valid = v;
    issue_op    = OPW'(op);
    issue_long  = lng;
    src0 = $urandom; src1 = $urandom; src2 = $urandom; src3 = $urandom;
    dst0 = RW'($urandom); dst1 = RW'($urandom);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) begin
      set_ops(1'b0, i, 1'b1);
      cycle(acc);
    end
  endtask

  // hold the request until accepted
  task automatic issue(input int op, input bit lng);
    bit acc;
    set_ops(1'b1, op, lng);
    acc = 0;
    while (!acc) cycle(acc);
    issue_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    q.delete();
    #1;
    chk(row_en == '0, "R1", "row_en in reset", 64'(row_en), 64'(0));
    chk(!res_valid, "R1", "res_valid in reset", 64'(res_valid), 64'(0));
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit acc;
    rst_ni = 1'b0;
    set_ops(1'b0, 0, 1'b1);
    @(negedge clk);
    do_reset();
    // R1: idle after release
    idle(3);
    chk(issue_ready == 1'b1, "R1", "ready after reset", 64'(issue_ready), 64'(1));

    // R3: every operation number alone, including the wrap above NUM_ROWS
    for (int op = 0; op < 16; op++) begin
      issue(op, 1'b1);
      idle(NR + 2);
    end

    // R6: short form, upper operands carry junk
    for (int op = 0; op < NR; op++) begin
      issue(op, 1'b0);
      idle(2);
    end
    idle(NR);

    // R8: rising lengths back to back
    for (int op = 0; op < NR; op++) begin
      set_ops(1'b1, op, op[0]);
      cycle(acc);
      chk(acc, "R8", "back-to-back accept", 64'(acc), 64'(1));
    end
    idle(NR + 2);

    // R7: falling lengths force stalls
    for (int op = NR - 1; op >= 0; op--) issue(op, 1'b1);
    idle(NR + 2);

    // R7: equal lengths are accepted back to back
    for (int i = 0; i < 5; i++) issue(3, 1'b1);
    idle(NR + 2);

    // mixed random traffic
    for (int i = 0; i < 300; i++) begin
      set_ops(($urandom % 3) != 0, int'($urandom % 16), $urandom % 2);
      cycle(acc);
    end
    idle(NR + 2);

    // R1: reset with operations in flight
    issue(7, 1'b1);
    issue(7, 1'b1);
    idle(2);
    do_reset();
    idle(NR + 2);

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule